// File: doc/BRIEF.md
# Pending Store Buffer with Acknowledged Commit

This block sits between a processor core and its private cache. It takes stores from the core into a small in-order queue, so the core never waits on the cache. The oldest queued store first sends out a request to invalidate its line in the peer caches. It then waits until every peer has acknowledged that request. Only then is it written to the cache and removed from the queue.

Loads from the core are checked against the queue before the cache data is used. If one or more queued stores match the load address, the value of the most recent of them is returned. Otherwise the cache's read data passes through unchanged. A store-barrier input stops any further store from entering while older stores are still queued, until the queue has emptied.

Top module: `store_commit_buf`

## Requirements
- R1: A store is accepted in the same cycle that `st_valid` and `st_ready` are both high. It becomes visible to loads from the next cycle, with no dependence on the cache.
- R2: When an entry becomes the oldest queued store, `inv_req` is high for exactly one cycle, with `inv_addr` equal to that entry's address. That cycle is the first one in which the entry is the oldest.
- R3: Acknowledgements count only in the cycles after the head's `inv_req` cycle. When the count reaches `PEERS`, `cache_wr_en` is high in the next cycle, with the head's address and data, and that entry is removed.
- R4: These acknowledgements are ignored: any arriving while the queue is empty, any in the `inv_req` cycle, any beyond `PEERS`, and any in a commit cycle. The count starts from zero for each new head.
- R5: Entries are written to the cache strictly in the order they were accepted, and never in two consecutive cycles.
- R6: If a load address matches one or more queued entries, `ld_fwd` is 1 and `ld_data` is the data of the most recently accepted of them, in the same cycle.
- R7: If a load address matches no entry, `ld_fwd` is 0 and `ld_data` equals `cache_rd_data`. In every case `cache_rd_addr` equals `ld_addr`.
- R8: While `DEPTH` entries are queued, `st_ready` is 0. It returns to 1 in the cycle after a commit.
- R9: If `st_fence` is high while the queue is not empty, `st_ready` is 0 in that cycle. It stays 0 until the queue is empty, even after `st_fence` falls. If `st_fence` is high while the queue is empty, it has no effect.
- R10: After a synchronous reset, the queue is empty, `st_ready` is 1, and `inv_req`, `cache_wr_en` and `ld_fwd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Core store request |
| st_addr | input | 16 | Store address |
| st_data | input | 32 | Store data |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_fence | input | 1 | Store barrier |
| ld_addr | input | 16 | Core load address |
| ld_data | output | 32 | Load result (forwarded or cache) |
| ld_fwd | output | 1 | Load result came from the queue |
| cache_rd_addr | output | 16 | Load address passed to the cache |
| cache_rd_data | input | 32 | Cache read data for the load |
| cache_wr_en | output | 1 | Commit write to the cache |
| cache_wr_addr | output | 16 | Commit address |
| cache_wr_data | output | 32 | Commit data |
| inv_req | output | 1 | Invalidate request for the head entry's line |
| inv_addr | output | 16 | Address to invalidate |
| inv_ack | input | 1 | One acknowledgement from one peer cache |

## Verification
The assertions assume that the core honours `st_ready`, so no store is offered into a full or fenced queue. They also assume that each peer acknowledges at most once per cycle, on a single pulse line. The random stimulus drives `st_valid` freely, but a store counts only when the bench's own model sees `st_ready` high. Acknowledgements are sent at random in any cycle, including those the block must ignore, which exercises the counter's saturation and reset rules. Addresses come from a set of four, so that several queued entries often share a line and the choice of the most recent match is exercised.

// File: rtl/scb_pkg.sv
package scb_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } entry_t;

    function automatic entry_t make_entry(input logic [ADDR_W-1:0] a,
                                          input logic [DATA_W-1:0] d);
        entry_t e;
        e.addr = a;
        e.data = d;
        return e;
    endfunction
endpackage

// File: rtl/scb_fifo.sv
module scb_fifo
    import scb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  entry_t push_ent,
    input  logic   pop,
    output entry_t head_ent,
    output logic   head_valid,
    output logic   full,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output entry_t age_ent [DEPTH],
    output logic   age_vld [DEPTH]
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    entry_t mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_ent;
                wr_ptr      <= wr_ptr + 1'b1;
            end
            if (pop) rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Entries listed oldest first
    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        assign age_ent[g] = mem[rd_ptr + PW'(g)];
        assign age_vld[g] = (CW'(g) < cnt);
    end

    assign head_ent   = mem[rd_ptr];
    assign head_valid = (cnt != '0);
    assign full       = (cnt == CW'(DEPTH));
    assign count      = cnt;

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt != CW'(DEPTH)));
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        pop |-> (cnt != '0));
endmodule

// File: rtl/scb_ack_ctrl.sv
module scb_ack_ctrl #(
    parameter int PEERS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic head_valid,
    input  logic ack,
    output logic inv_req,
    output logic commit
);
    localparam int AKW = $clog2(PEERS+1);

    logic           issued;
    logic [AKW-1:0] ack_cnt;

    assign inv_req = head_valid && !issued;
    assign commit  = head_valid && issued && (ack_cnt == AKW'(PEERS));

    always_ff @(posedge clk) begin
        if (rst || commit) begin
            issued  <= 1'b0;
            ack_cnt <= '0;
        end else begin
            if (inv_req) issued <= 1'b1;
            if (issued && ack && (ack_cnt != AKW'(PEERS)))
                ack_cnt <= ack_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst) assert_ack_cap_R4: assert (ack_cnt <= AKW'(PEERS));
    end

    assert_inv_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        inv_req |=> !inv_req);
    assert_commit_gap_R5: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);
endmodule

// File: rtl/scb_fwd.sv
module scb_fwd
    import scb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  entry_t             age_ent [DEPTH],
    input  logic               age_vld [DEPTH],
    input  logic [ADDR_W-1:0]  ld_addr,
    input  logic [DATA_W-1:0]  cache_data,
    output logic [DATA_W-1:0]  ld_data,
    output logic               ld_fwd
);
    logic [DATA_W-1:0] hit_data;

    // Later (younger) matches override earlier ones
    always_comb begin
        ld_fwd   = 1'b0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (age_vld[i] && (age_ent[i].addr == ld_addr)) begin
                ld_fwd   = 1'b1;
                hit_data = age_ent[i].data;
            end
        end
    end

    assign ld_data = ld_fwd ? hit_data : cache_data;
endmodule

// File: rtl/store_commit_buf.sv
module store_commit_buf
    import scb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PEERS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_ready,
    input  logic              st_fence,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_fwd,
    output logic [ADDR_W-1:0] cache_rd_addr,
    input  logic [DATA_W-1:0] cache_rd_data,
    output logic              cache_wr_en,
    output logic [ADDR_W-1:0] cache_wr_addr,
    output logic [DATA_W-1:0] cache_wr_data,
    output logic              inv_req,
    output logic [ADDR_W-1:0] inv_addr,
    input  logic              inv_ack
);
    localparam int CW = $clog2(DEPTH+1);

    entry_t         head_ent;
    entry_t         age_ent [DEPTH];
    logic           age_vld [DEPTH];
    logic           head_valid, full, push, commit;
    logic [CW-1:0]  count;
    logic           drain_q, fence_block;

    assign fence_block = drain_q || (st_fence && head_valid);
    assign st_ready    = !full && !fence_block;
    assign push        = st_valid && st_ready;

    always_ff @(posedge clk) begin
        if (rst) drain_q <= 1'b0;
        else     drain_q <= fence_block && (count != CW'(commit));
    end

    scb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push),
        .push_ent(make_entry(st_addr, st_data)),
        .pop(commit), .head_ent(head_ent), .head_valid(head_valid),
        .full(full), .count(count), .age_ent(age_ent), .age_vld(age_vld)
    );

    scb_ack_ctrl #(.PEERS(PEERS)) u_ack (
        .clk(clk), .rst(rst), .head_valid(head_valid), .ack(inv_ack),
        .inv_req(inv_req), .commit(commit)
    );

    scb_fwd #(.DEPTH(DEPTH)) u_fwd (
        .age_ent(age_ent), .age_vld(age_vld), .ld_addr(ld_addr),
        .cache_data(cache_rd_data), .ld_data(ld_data), .ld_fwd(ld_fwd)
    );

    assign cache_rd_addr = ld_addr;
    assign cache_wr_en   = commit;
    assign cache_wr_addr = head_ent.addr;
    assign cache_wr_data = head_ent.data;
    assign inv_addr      = head_ent.addr;

    assert_fence_hold_R9: assert property (@(posedge clk) disable iff (rst)
        drain_q |-> !st_ready);
    assert_wr_needs_inv_R3: assert property (@(posedge clk) disable iff (rst)
        inv_req |-> !cache_wr_en);
endmodule

// File: tb/store_commit_buf_test.sv
`timescale 1ns/1ps
module store_commit_buf_test;
    localparam int DEPTH = 4;
    localparam int PEERS = 3;

    logic        clk = 0, rst = 1;
    logic        st_valid = 0, st_fence = 0, inv_ack = 0;
    logic [15:0] st_addr = 0, ld_addr = 0;
    logic [31:0] st_data = 0, cache_rd_data = 0;
    logic        st_ready, ld_fwd, cache_wr_en, inv_req;
    logic [31:0] ld_data, cache_wr_data;
    logic [15:0] cache_rd_addr, cache_wr_addr, inv_addr;

    always #4 clk = ~clk;

    store_commit_buf #(.DEPTH(DEPTH), .PEERS(PEERS)) uut (.*);

    int checks = 0, errors = 0;
    logic [15:0] q_a [DEPTH];
    logic [31:0] q_d [DEPTH];
    int m_cnt = 0, m_ack = 0;
    bit m_iss = 0, m_drain = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_ready(input bit f);
        return (m_cnt < DEPTH) && !(m_drain || (f && m_cnt != 0));
    endfunction

    // One cycle: drive at negedge, compare, then advance model
    task automatic cyc(input bit sv, input logic [15:0] sa, input logic [31:0] sd,
                       input bit f, input bit ak, input logic [15:0] la, input logic [31:0] cd);
        bit er, ei, ew, hit, push;
        logic [31:0] fd;
        @(negedge clk);
        st_valid = sv; st_addr = sa; st_data = sd; st_fence = f;
        inv_ack = ak; ld_addr = la; cache_rd_data = cd;
        #1;
        er = exp_ready(f);
        ei = (m_cnt != 0) && !m_iss;
        ew = (m_cnt != 0) && m_iss && (m_ack == PEERS);
        hit = 0; fd = cd;
        for (int i = 0; i < m_cnt; i++) if (q_a[i] == la) begin hit = 1; fd = q_d[i]; end
        chk(st_ready === er, (f || m_drain) ? "R9 st_ready fence" : "R8 st_ready", 32'(st_ready), 32'(er));
        chk(inv_req === ei, "R2 inv_req", 32'(inv_req), 32'(ei));
        if (ei) chk(inv_addr === q_a[0], "R2 inv_addr", 32'(inv_addr), 32'(q_a[0]));
        chk(cache_wr_en === ew, "R3 R4 cache_wr_en", 32'(cache_wr_en), 32'(ew));
        if (ew) begin
            chk(cache_wr_addr === q_a[0], "R5 wr_addr order", 32'(cache_wr_addr), 32'(q_a[0]));
            chk(cache_wr_data === q_d[0], "R5 wr_data order", cache_wr_data, q_d[0]);
        end
        chk(ld_fwd === hit, hit ? "R6 ld_fwd" : "R7 ld_fwd", 32'(ld_fwd), 32'(hit));
        chk(ld_data === fd, hit ? "R6 ld_data youngest" : "R7 ld_data pass", ld_data, fd);
        chk(cache_rd_addr === la, "R7 cache_rd_addr", 32'(cache_rd_addr), 32'(la));
        push = sv && er;
        if (ew) begin
            for (int i = 0; i < DEPTH-1; i++) begin q_a[i] = q_a[i+1]; q_d[i] = q_d[i+1]; end
            m_cnt--; m_iss = 0; m_ack = 0;
        end else begin
            if (m_iss && ak && m_ack < PEERS) m_ack++;
            if (ei) m_iss = 1;
        end
        m_drain = (m_drain || (f && (m_cnt + (ew ? 1 : 0)) != 0)) && (m_cnt != 0);
        if (push) begin q_a[m_cnt] = sa; q_d[m_cnt] = sd; m_cnt++; end   // R1
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk(st_ready === 1'b1, "R10 reset st_ready", 32'(st_ready), 1);
        chk(inv_req === 1'b0, "R10 reset inv_req", 32'(inv_req), 0);
        chk(cache_wr_en === 1'b0, "R10 reset wr_en", 32'(cache_wr_en), 0);
        chk(ld_fwd === 1'b0, "R10 reset ld_fwd", 32'(ld_fwd), 0);
        // R1 R8: fill without acks; duplicate addresses for R6
        cyc(1, 16'h10, 32'hA1, 0, 0, 16'h10, 32'h55);
        cyc(1, 16'h20, 32'hA2, 0, 1, 16'h10, 32'h55);   // ack in inv cycle: R4
        cyc(1, 16'h10, 32'hA3, 0, 0, 16'h10, 32'h55);
        cyc(1, 16'h30, 32'hA4, 0, 0, 16'h10, 32'h55);
        cyc(1, 16'h40, 32'hA5, 0, 0, 16'h40, 32'h66);   // full: refused, R8
        // R3 R4: extra acks past PEERS
        for (int i = 0; i < PEERS + 2; i++) cyc(0, 0, 0, 0, 1, 16'h20, 32'h77);
        // R9: fence held one cycle, then drain
        cyc(1, 16'h50, 32'hB1, 1, 0, 16'h50, 32'h0);
        for (int i = 0; i < 20; i++) cyc(1, 16'h50, 32'hB2, 0, 1, 16'h10, 32'h1);
        cyc(0, 0, 0, 1, 0, 0, 0);  // fence on empty queue
        for (int i = 0; i < 4000; i++)
            cyc($urandom_range(0, 1), 16'($urandom_range(0, 3)), $urandom,
                ($urandom_range(0, 19) == 0), ($urandom_range(0, 9) < 4),
                16'($urandom_range(0, 4)), $urandom);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule